// File: doc/BRIEF.md
# Byte Mailbox Message Engine

This engine sits on the host side of a byte-wide mailbox shared with an embedded controller. One transaction is run at a time. A send writes a four-byte header (command code, target id, length high byte, length low byte), then streams the payload bytes taken from the host one by one. A receive reads a four-byte header in the same layout and compares it with the command code, target id and length the host expects. If all three agree, the payload bytes are handed out in order. If any of them differs, the engine reads and discards as many bytes as the received length field claims, so the mailbox stays aligned for the next message, and then reports an invalid-message status.

Every mailbox byte is moved only after the relevant flag has been seen clear: the full flag for writes and the empty flag for reads. The flag is examined once every `POLL_CYC` cycles. If a wait lasts `TIMEOUT_CYC` cycles, the transaction is abandoned with a timeout status. The mailbox read port is a word, and only its low byte carries data.

Top module: `mbx_msg_engine`

## Requirements
- R1: After synchronous reset, busy, done, mb_wr_en, mb_rd_en, tx_pop and rx_valid are all 0.
- R2: A send (req_recv=0) writes, in this order: opcode, module id, length[15:8], length[7:0], then exactly `length` payload bytes taken from tx_data, with one tx_pop per payload byte. A zero length writes only the header. It ends with status 0 (OK).
- R3: A byte is written on mb_wr_en only if mb_full was sampled low in the cycle before. No write happens while mb_full is held high.
- R4: A byte is read on mb_rd_en only if mb_empty was sampled low in the cycle before. Only mb_rd_data[7:0] is used, and the upper bits have no effect.
- R5: A receive (req_recv=1) whose header matches the expected opcode, module id and 16-bit length outputs the payload bytes in order on rx_data with rx_valid. It ends with status 0 (OK).
- R6: A receive whose opcode, module id or length differs reads exactly the received length of further bytes and discards them. rx_valid is never raised, bytes queued after the message are left in the mailbox, and the transaction ends with status 1 (INVALID).
- R7: A flag wait that lasts TIMEOUT_CYC cycles ends the transaction with status 2 (TIMEOUT). No further mailbox access follows.
- R8: busy is high from the cycle after req_start is accepted until done. req_start while busy is ignored.
- R9: done is a one-cycle pulse. status keeps its value until the next transaction is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_start | input | 1 | Start a transaction (taken only when idle) |
| req_recv | input | 1 | 1 = receive, 0 = send |
| req_opcode | input | 8 | Command code sent, or expected on receive |
| req_module | input | 8 | Target id sent, or expected on receive |
| req_len | input | 16 | Payload length sent, or expected on receive |
| tx_data | input | 8 | Current payload byte for a send |
| tx_pop | output | 1 | Current payload byte consumed |
| mb_full | input | 1 | Mailbox cannot take a byte |
| mb_empty | input | 1 | Mailbox holds no byte |
| mb_rd_data | input | MBX_W | Mailbox read word; low byte is data |
| mb_wr_en | output | 1 | Write mb_wr_data to the mailbox |
| mb_wr_data | output | 8 | Byte being written |
| mb_rd_en | output | 1 | Pop the byte just read |
| rx_valid | output | 1 | rx_data holds a received payload byte |
| rx_data | output | 8 | Received payload byte |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | Transaction finished (one cycle) |
| status | output | 2 | 0 OK, 1 INVALID, 2 TIMEOUT |

## Verification
The bench targets headers that differ in only one field: opcode, module id or length, including a received length of zero. A design that compared only part of the header would stream garbage payload. A design that drained by the expected length instead of the received one would leave the mailbox out of step, and the bench sees this from the sentinel byte left behind. Stalls on both flags check that no byte moves while a flag is set, and held flags check the timeout path. The read word carries nonzero upper bits, so a design that used more than the low byte would be caught. A second start pulse during a stalled send checks that the transaction in progress is not disturbed.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int HDR_BYTES = 4;
  localparam int LEN_W     = 16;

  typedef enum logic [1:0] {
    ST_OK  = 2'd0,
    ST_BAD = 2'd1,
    ST_TMO = 2'd2
  } mbx_status_e;

  typedef enum logic [2:0] {
    S_IDLE, S_WWAIT, S_WGAP, S_RWAIT, S_RGAP
  } mbx_state_e;

  typedef enum logic [1:0] {
    PH_HDR, PH_PAY, PH_DRAIN
  } mbx_phase_e;
endpackage

// File: rtl/mbx_poll_timer.sv
module mbx_poll_timer #(
  parameter int POLL_CYC    = 2,
  parameter int TIMEOUT_CYC = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic flag_set,
  output logic go,
  output logic expired
);
  localparam int PW = $clog2(POLL_CYC + 1);
  localparam int TW = $clog2(TIMEOUT_CYC + 1);

  logic [PW-1:0] poll_q;
  logic [TW-1:0] elapsed_q;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      poll_q    <= '0;
      elapsed_q <= '0;
    end else begin
      poll_q <= (poll_q == '0) ? PW'(POLL_CYC - 1) : poll_q - PW'(1);
      if (elapsed_q != TW'(TIMEOUT_CYC))
        elapsed_q <= elapsed_q + TW'(1);
    end
  end

  assign go      = (poll_q == '0) && !flag_set;
  assign expired = !go && (elapsed_q >= TW'(TIMEOUT_CYC - 1));
endmodule

// File: rtl/mbx_hdr_match.sv
module mbx_hdr_match (
  input  logic [7:0]  exp_op,
  input  logic [7:0]  exp_mod,
  input  logic [15:0] exp_len,
  input  logic [31:0] hdr,
  output logic        match,
  output logic [15:0] rx_len
);
  assign rx_len = hdr[15:0];
  assign match  = (hdr[31:24] == exp_op) && (hdr[23:16] == exp_mod) &&
                  (hdr[15:0] == exp_len);
endmodule

// File: rtl/mbx_msg_engine.sv
module mbx_msg_engine
  import mbx_pkg::*;
#(
  parameter int POLL_CYC    = 2,
  parameter int TIMEOUT_CYC = 64,
  parameter int MBX_W       = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_start,
  input  logic             req_recv,
  input  logic [7:0]       req_opcode,
  input  logic [7:0]       req_module,
  input  logic [15:0]      req_len,
  input  logic [7:0]       tx_data,
  output logic             tx_pop,
  input  logic             mb_full,
  input  logic             mb_empty,
  input  logic [MBX_W-1:0] mb_rd_data,
  output logic             mb_wr_en,
  output logic [7:0]       mb_wr_data,
  output logic             mb_rd_en,
  output logic             rx_valid,
  output logic [7:0]       rx_data,
  output logic             busy,
  output logic             done,
  output logic [1:0]       status
);
  localparam int IDX_W = $clog2(HDR_BYTES);

  mbx_state_e        state;
  mbx_phase_e        phase;
  logic [IDX_W-1:0]  idx;
  logic [LEN_W-1:0]  remain;
  logic [7:0]        exp_op, exp_mod;
  logic [LEN_W-1:0]  exp_len;
  logic [HDR_BYTES-1:0][7:0] hdr_q;
  logic [7:0]        hdr_byte, send_byte, rd_byte;
  logic              in_wait, flag_set, go, expired, match;
  logic [LEN_W-1:0]  rx_len;
  logic              last_hdr;
  wire               unused_hi_bits = ^mb_rd_data[MBX_W-1:8];

  assign in_wait  = (state == S_WWAIT) || (state == S_RWAIT);
  assign flag_set = (state == S_WWAIT) ? mb_full : mb_empty;
  assign rd_byte  = mb_rd_data[7:0];
  assign last_hdr = (idx == IDX_W'(HDR_BYTES - 1));

  mbx_poll_timer #(.POLL_CYC(POLL_CYC), .TIMEOUT_CYC(TIMEOUT_CYC)) u_timer (
    .clk(clk), .rst(rst), .clear(!in_wait), .flag_set(flag_set),
    .go(go), .expired(expired)
  );

  mbx_hdr_match u_match (
    .exp_op(exp_op), .exp_mod(exp_mod), .exp_len(exp_len),
    .hdr(hdr_q), .match(match), .rx_len(rx_len)
  );

  always_comb begin
    case (idx)
      2'd0:    hdr_byte = exp_op;
      2'd1:    hdr_byte = exp_mod;
      2'd2:    hdr_byte = exp_len[15:8];
      default: hdr_byte = exp_len[7:0];
    endcase
    send_byte = (phase == PH_HDR) ? hdr_byte : tx_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= S_IDLE;
      phase      <= PH_HDR;
      idx        <= '0;
      remain     <= '0;
      exp_op     <= '0;
      exp_mod    <= '0;
      exp_len    <= '0;
      hdr_q      <= '0;
      mb_wr_en   <= 1'b0;
      mb_wr_data <= '0;
      mb_rd_en   <= 1'b0;
      tx_pop     <= 1'b0;
      rx_valid   <= 1'b0;
      rx_data    <= '0;
      busy       <= 1'b0;
      done       <= 1'b0;
      status     <= ST_OK;
    end else begin
      mb_wr_en <= 1'b0;
      mb_rd_en <= 1'b0;
      tx_pop   <= 1'b0;
      rx_valid <= 1'b0;
      done     <= 1'b0;
      case (state)
        S_IDLE: if (req_start) begin
          exp_op  <= req_opcode;
          exp_mod <= req_module;
          exp_len <= req_len;
          idx     <= '0;
          phase   <= PH_HDR;
          busy    <= 1'b1;
          status  <= ST_OK;
          state   <= req_recv ? S_RWAIT : S_WWAIT;
        end
        S_WWAIT: begin
          if (go) begin
            mb_wr_en   <= 1'b1;
            mb_wr_data <= send_byte;
            tx_pop     <= (phase == PH_PAY);
            state      <= S_WGAP;
          end else if (expired) begin
            busy <= 1'b0; done <= 1'b1; status <= ST_TMO; state <= S_IDLE;
          end
        end
        S_WGAP: begin
          if (phase == PH_HDR) begin
            if (!last_hdr) begin
              idx <= idx + IDX_W'(1); state <= S_WWAIT;
            end else if (exp_len == '0) begin
              busy <= 1'b0; done <= 1'b1; status <= ST_OK; state <= S_IDLE;
            end else begin
              phase <= PH_PAY; remain <= exp_len; state <= S_WWAIT;
            end
          end else if (remain == LEN_W'(1)) begin
            busy <= 1'b0; done <= 1'b1; status <= ST_OK; state <= S_IDLE;
          end else begin
            remain <= remain - LEN_W'(1); state <= S_WWAIT;
          end
        end
        S_RWAIT: begin
          if (go) begin
            mb_rd_en <= 1'b1;
            if (phase == PH_HDR) hdr_q[HDR_BYTES-1-int'(idx)] <= rd_byte;
            if (phase == PH_PAY) begin
              rx_valid <= 1'b1; rx_data <= rd_byte;
            end
            state <= S_RGAP;
          end else if (expired) begin
            busy <= 1'b0; done <= 1'b1; status <= ST_TMO; state <= S_IDLE;
          end
        end
        S_RGAP: begin
          if (phase == PH_HDR) begin
            if (!last_hdr) begin
              idx <= idx + IDX_W'(1); state <= S_RWAIT;
            end else if (match) begin
              if (exp_len == '0) begin
                busy <= 1'b0; done <= 1'b1; status <= ST_OK; state <= S_IDLE;
              end else begin
                phase <= PH_PAY; remain <= exp_len; state <= S_RWAIT;
              end
            end else if (rx_len == '0) begin
              busy <= 1'b0; done <= 1'b1; status <= ST_BAD; state <= S_IDLE;
            end else begin
              phase <= PH_DRAIN; remain <= rx_len; state <= S_RWAIT;
            end
          end else if (remain == LEN_W'(1)) begin
            busy   <= 1'b0;
            done   <= 1'b1;
            status <= (phase == PH_PAY) ? ST_OK : ST_BAD;
            state  <= S_IDLE;
          end else begin
            remain <= remain - LEN_W'(1); state <= S_RWAIT;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R3: a write only follows a cycle in which the full flag was low
  p_wr_room_r3: assert property (@(posedge clk) disable iff (rst)
    mb_wr_en |-> $past(!mb_full));
  // R4: a read only follows a cycle in which the empty flag was low
  p_rd_data_r4: assert property (@(posedge clk) disable iff (rst)
    mb_rd_en |-> $past(!mb_empty));
  // R2: never a read and a write in the same cycle
  p_one_dir_r2: assert property (@(posedge clk) disable iff (rst)
    !(mb_wr_en && mb_rd_en));
  // R9: done lasts one cycle
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R8: busy is low once done is signalled
  p_done_idle_r8: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
  // R5: payload output only inside a transaction
  p_rx_busy_r5: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> busy);
endmodule

// File: tb/mbx_msg_engine_bench.sv
module mbx_msg_engine_bench;
  localparam int CLK_PERIOD = 10;
  localparam int TMO = 64;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_start = 1'b0, req_recv = 1'b0;
  logic [7:0] req_opcode = '0, req_module = '0;
  logic [15:0] req_len = '0;
  logic [7:0] tx_data;
  logic tx_pop, mb_full, mb_empty, mb_wr_en, mb_rd_en, rx_valid, busy, done;
  logic [31:0] mb_rd_data;
  logic [7:0] mb_wr_data, rx_data;
  logic [1:0] status;

  logic force_full = 1'b0, force_empty = 1'b0;
  logic q_empty = 1'b1;
  logic [7:0] q_head = '0;
  logic [7:0] rq[$];
  logic [7:0] exp_wr[$];
  logic [7:0] exp_rx[$];
  logic [7:0] payload [0:63];
  int tx_idx = 0, wr_count = 0, rd_count = 0, rx_count = 0, done_cnt = 0;
  int checks = 0, fails = 0, cycles = 0;
  logic prev_done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign mb_full    = force_full;
  assign mb_empty   = force_empty || q_empty;
  assign mb_rd_data = {24'hA5C3F0, q_head};
  assign tx_data    = payload[tx_idx[5:0]];

  mbx_msg_engine #(.POLL_CYC(2), .TIMEOUT_CYC(TMO), .MBX_W(32)) u_mbx_msg_engine (
    .clk(clk), .rst(rst), .req_start(req_start), .req_recv(req_recv),
    .req_opcode(req_opcode), .req_module(req_module), .req_len(req_len),
    .tx_data(tx_data), .tx_pop(tx_pop), .mb_full(mb_full), .mb_empty(mb_empty),
    .mb_rd_data(mb_rd_data), .mb_wr_en(mb_wr_en), .mb_wr_data(mb_wr_data),
    .mb_rd_en(mb_rd_en), .rx_valid(rx_valid), .rx_data(rx_data),
    .busy(busy), .done(done), .status(status)
  );

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  // mailbox model and scoreboard monitor, away from the active edge
  always @(negedge clk) begin
    if (mb_wr_en) begin
      wr_count++;
      if (exp_wr.size() == 0) check(1'b0, "R2 unexpected write", int'(mb_wr_data), -1);
      else begin
        logic [7:0] e;
        e = exp_wr.pop_front();
        check(mb_wr_data == e, "R2 write byte", int'(mb_wr_data), int'(e));
      end
    end
    if (mb_rd_en) begin
      rd_count++;
      if (rq.size() > 0) void'(rq.pop_front());
    end
    if (rx_valid) begin
      rx_count++;
      if (exp_rx.size() == 0) check(1'b0, "R6 unexpected rx byte", int'(rx_data), -1);
      else begin
        logic [7:0] e;
        e = exp_rx.pop_front();
        check(rx_data == e, "R5 rx byte", int'(rx_data), int'(e));
      end
    end
    if (tx_pop) tx_idx++;
    if (done) begin
      done_cnt++;
      if (prev_done) check(1'b0, "R9 done longer than one cycle", 2, 1);
    end
    prev_done = done;
    q_empty = (rq.size() == 0);
    q_head  = (rq.size() > 0) ? rq[0] : 8'h00;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  task automatic start_txn(input bit recv, input logic [7:0] op, input logic [7:0] md,
                           input logic [15:0] len);
    @(posedge clk); #1;
    req_recv = recv; req_opcode = op; req_module = md; req_len = len; req_start = 1'b1;
    @(posedge clk); #1;
    req_start = 1'b0;
    check(busy == 1'b1, "R8 busy after accept", int'(busy), 1);
  endtask

  task automatic wait_done();
    int d0;
    d0 = done_cnt;
    while (done_cnt == d0) @(negedge clk);
    @(negedge clk);
    check(busy == 1'b0, "R8 busy low after done", int'(busy), 0);
  endtask

  task automatic do_send(input logic [7:0] op, input logic [7:0] md, input int len,
                         input logic [7:0] seed);
    for (int i = 0; i < len; i++) payload[i] = seed + 8'(i * 7);
    tx_idx = 0;
    exp_wr.push_back(op); exp_wr.push_back(md);
    exp_wr.push_back(8'(len >> 8)); exp_wr.push_back(8'(len));
    for (int i = 0; i < len; i++) exp_wr.push_back(payload[i]);
    start_txn(1'b0, op, md, 16'(len));
    wait_done();
    check(status == 2'd0, "R2 send status OK", int'(status), 0);
    check(exp_wr.size() == 0, "R2 all bytes written", exp_wr.size(), 0);
    check(tx_idx == len, "R2 payload pops", tx_idx, len);
  endtask

  task automatic load_msg(input logic [7:0] op, input logic [7:0] md, input int len,
                          input logic [7:0] seed, input bit expect_out);
    rq.push_back(op); rq.push_back(md); rq.push_back(8'(len >> 8)); rq.push_back(8'(len));
    for (int i = 0; i < len; i++) begin
      rq.push_back(seed ^ 8'(i * 13));
      if (expect_out) exp_rx.push_back(seed ^ 8'(i * 13));
    end
  endtask

  task automatic do_recv_ok(input logic [7:0] op, input logic [7:0] md, input int len,
                            input logic [7:0] seed);
    load_msg(op, md, len, seed, 1'b1);
    start_txn(1'b1, op, md, 16'(len));
    wait_done();
    check(status == 2'd0, "R5 recv status OK", int'(status), 0);
    check(exp_rx.size() == 0, "R5 all payload out", exp_rx.size(), 0);
  endtask

  task automatic do_recv_bad(input logic [7:0] eop, input logic [7:0] emd, input int elen,
                             input logic [7:0] aop, input logic [7:0] amd, input int alen);
    int rx0;
    rx0 = rx_count;
    load_msg(aop, amd, alen, 8'h3C, 1'b0);
    rq.push_back(8'hEE);
    start_txn(1'b1, eop, emd, 16'(elen));
    wait_done();
    check(status == 2'd1, "R6 mismatch status INVALID", int'(status), 1);
    check(rq.size() == 1, "R6 drained exactly received length", rq.size(), 1);
    check(rq.size() > 0 && rq[0] == 8'hEE, "R6 sentinel kept", rq.size() > 0 ? int'(rq[0]) : -1, 238);
    check(rx_count == rx0, "R6 no payload output", rx_count - rx0, 0);
    rq.delete();
    @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) payload[i] = '0;
    repeat (3) @(posedge clk);
    #1;
    check(busy == 0 && done == 0 && mb_wr_en == 0 && mb_rd_en == 0 && tx_pop == 0 && rx_valid == 0,
          "R1 reset outputs", int'({busy, done, mb_wr_en, mb_rd_en, tx_pop, rx_valid}), 0);
    rst = 1'b0;

    // R2: sends of several lengths including zero
    do_send(8'h11, 8'h01, 6, 8'h40);
    do_send(8'h22, 8'h02, 0, 8'h00);
    do_send(8'hF3, 8'h7E, 1, 8'h99);

    // R3: full flag stall, then release before timeout
    begin
      int w0;
      force_full = 1'b1;
      for (int i = 0; i < 3; i++) payload[i] = 8'hB0 + 8'(i);
      tx_idx = 0;
      exp_wr.push_back(8'h33); exp_wr.push_back(8'h03);
      exp_wr.push_back(8'h00); exp_wr.push_back(8'h03);
      for (int i = 0; i < 3; i++) exp_wr.push_back(payload[i]);
      w0 = wr_count;
      start_txn(1'b0, 8'h33, 8'h03, 16'd3);
      // R8: a second start while busy must be ignored
      req_recv = 1'b1; req_opcode = 8'h77; req_start = 1'b1;
      @(posedge clk); #1; req_start = 1'b0;
      repeat (20) @(negedge clk);
      check(wr_count == w0, "R3 no write while full", wr_count - w0, 0);
      force_full = 1'b0;
      wait_done();
      check(status == 2'd0, "R3 stalled send OK", int'(status), 0);
      check(exp_wr.size() == 0, "R8 send intact after ignored start", exp_wr.size(), 0);
      repeat (5) @(negedge clk);
      check(busy == 1'b0, "R8 ignored start began nothing", int'(busy), 0);
    end

    // R5/R4: matched receives, upper read bits nonzero
    do_recv_ok(8'h44, 8'h04, 5, 8'h21);
    do_recv_ok(8'h45, 8'h05, 0, 8'h00);

    // R4: empty flag stall
    begin
      int r0;
      force_empty = 1'b1;
      load_msg(8'h46, 8'h06, 2, 8'h8D, 1'b1);
      r0 = rd_count;
      start_txn(1'b1, 8'h46, 8'h06, 16'd2);
      repeat (20) @(negedge clk);
      check(rd_count == r0, "R4 no read while empty", rd_count - r0, 0);
      force_empty = 1'b0;
      wait_done();
      check(status == 2'd0, "R4 stalled recv OK", int'(status), 0);
    end

    // R6: each header field mismatched
    do_recv_bad(8'h50, 8'h01, 3, 8'h51, 8'h01, 3);
    do_recv_bad(8'h50, 8'h01, 3, 8'h50, 8'h02, 3);
    do_recv_bad(8'h50, 8'h01, 3, 8'h50, 8'h01, 5);
    do_recv_bad(8'h50, 8'h01, 3, 8'h50, 8'h01, 0);
    do_recv_bad(8'h50, 8'h01, 3, 8'h50, 8'h01, 259);

    // R7: timeout on a held full flag and on an empty mailbox
    begin
      int w0, r0;
      force_full = 1'b1;
      w0 = wr_count;
      start_txn(1'b0, 8'h60, 8'h01, 16'd2);
      wait_done();
      check(status == 2'd2, "R7 send timeout status", int'(status), 2);
      force_full = 1'b0;
      repeat (10) @(negedge clk);
      check(wr_count == w0, "R7 no write after timeout", wr_count - w0, 0);
      exp_wr.delete();
      r0 = rd_count;
      start_txn(1'b1, 8'h61, 8'h01, 16'd2);
      wait_done();
      check(status == 2'd2, "R7 recv timeout status", int'(status), 2);
      check(rd_count == r0, "R7 no read on timeout", rd_count - r0, 0);
      repeat (4) @(negedge clk);
      check(status == 2'd2, "R9 status held after done", int'(status), 2);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule